// File: doc/BRIEF.md
# Prescaled Multi-Channel Conversion Controller

This block sits on a simple 32-bit register bus and sequences conversions for a multi-channel converter. Software programs one control word. That word picks an input channel, a reference, a clock divider, the enable and interrupt-enable settings, and a start/busy bit. The block then counts a fixed number of prescaled clock ticks and captures a scaled, saturated result in a read-only result word. It can also raise a level interrupt.

The analog side is modelled by digital ports. Each channel's sample and the internal and external reference values arrive as 32-bit unsigned inputs. The channel and reference used are the ones held in the control word when the conversion completes. Software clears the interrupt by writing one to its flag. A soft-reset bit in the control word puts the whole block back to its power-up state.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset the control word reads 0x000C0001, the result word reads 0 and `irq` is low, although control bit 18 (the flag) reads 1.
- R2: The control word is at byte offset 0x0 and the result word at 0x4. Any other offset, including a misaligned one, reads 0. Writes to the result word change nothing.
- R3: A conversion starts only on a control write that has enable (bit 17) set and that moves start (bit 13) from 0 to 1. It completes exactly 20 × 2 × (div + 1) clock cycles after that write, where div is bits 8:1. Bit 13 reads 1 until completion.
- R4: On completion the result word is sample × 1024 / reference, capped at 1023. The sample comes from the channel in bits 27:24. Bit 19 = 1 selects the internal reference and 0 selects the external one.
- R5: Completion clears bit 13. When interrupt enable (bit 21) is set, completion also sets the flag (bit 18) and drives `irq` high.
- R6: Writing 1 to bit 18 clears the flag and drops `irq`. Writing 0 to bit 18 leaves a pending flag and `irq` unchanged.
- R7: A control write with enable set and start at 0 aborts a running conversion. A write that keeps start at 1 does not restart the count.
- R8: A control write with bit 16 set restores all reset values, cancels any running conversion and drops `irq`. The rest of the written value is discarded.
- R9: If the channel field is 8 or above at completion, the result word is left unchanged, bit 13 stays set and no interrupt is raised.
- R10: A start written while enable is 0 stores bit 13 but runs no conversion, so the result word never changes.
- R11: With interrupt enable clear, a completion leaves the flag and `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| chan_in | input | 256 | Eight 32-bit channel samples, channel k at bits 32k+31:32k |
| ref_int | input | 32 | Internal reference value, nonzero |
| ref_ext | input | 32 | External reference value, nonzero |
| irq | output | 1 | Level interrupt |

## Verification
The bench runs random conversions with random channels, dividers, reference choices and interrupt settings. Samples fall mostly below the reference, so the division itself is exercised. Every fourth sample is a full 32-bit value, which separates correct saturation from wrapped quotients. Each random conversion is sampled one cycle before and at its exact completion cycle, so a prescaler that is off by one cycle shows up. Directed cases cover the results of partial writes: abort, a repeated start, soft reset mid-conversion, an invalid channel, a start while disabled, and the write-one and write-zero paths of the flag.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;

    localparam int SAMPLE_W = 32;
    localparam int RES_W    = 10;
    localparam int DIV_W    = 8;
    localparam int CHSEL_W  = 4;

    localparam logic [31:0] CTL_RST_VAL = 32'h000C_0001;

    typedef struct packed {
        logic [3:0]         rsv_top;
        logic [CHSEL_W-1:0] chan;
        logic [1:0]         rsv_b;
        logic               int_en;
        logic               rsv_c;
        logic               ref_int;
        logic               flag;
        logic               enable;
        logic               srst;
        logic [1:0]         rsv_d;
        logic               start;
        logic [3:0]         rsv_e;
        logic [DIV_W-1:0]   div;
        logic               rsv_lsb;
    } ctl_t;

    typedef enum logic [1:0] {
        SEL_CTL,
        SEL_RES,
        SEL_NONE
    } reg_sel_e;

    // sample * 2^RES_W / ref, capped at all-ones
    function automatic logic [RES_W-1:0] ratio_scale(
        input logic [SAMPLE_W-1:0] smp,
        input logic [SAMPLE_W-1:0] rv
    );
        logic [SAMPLE_W+RES_W-1:0] num;
        logic [SAMPLE_W+RES_W-1:0] quo;
        num = {smp, {RES_W{1'b0}}};
        if (rv == '0) begin
            return '1;
        end
        quo = num / {{RES_W{1'b0}}, rv};
        if (|quo[SAMPLE_W+RES_W-1:RES_W]) begin
            return '1;
        end
        return quo[RES_W-1:0];
    endfunction

endpackage

// File: rtl/adc_tick_timer.sv
module adc_tick_timer #(
    parameter int DIV_W      = 8,
    parameter int CONV_TICKS = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             abort,
    input  logic [DIV_W-1:0] div,
    output logic             done
);
    localparam int PRE_W  = DIV_W + 1;
    localparam int TICK_W = (CONV_TICKS > 1) ? $clog2(CONV_TICKS) : 1;

    logic              running;
    logic [PRE_W-1:0]  pre_cnt;
    logic [PRE_W-1:0]  pre_top;
    logic [TICK_W-1:0] tick_cnt;

    assign done = running && (pre_cnt == '0) && (tick_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            running  <= 1'b0;
            pre_cnt  <= '0;
            pre_top  <= '0;
            tick_cnt <= '0;
        end else if (load) begin
            running  <= 1'b1;
            pre_cnt  <= {div, 1'b1};
            pre_top  <= {div, 1'b1};
            tick_cnt <= TICK_W'(CONV_TICKS - 1);
        end else if (running) begin
            if (pre_cnt == '0) begin
                if (tick_cnt == '0) begin
                    running <= 1'b0;
                end else begin
                    tick_cnt <= tick_cnt - 1'b1;
                    pre_cnt  <= pre_top;
                end
            end else begin
                pre_cnt <= pre_cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_chan_scaler.sv
module adc_chan_scaler
    import adc_conv_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [NUM_CH*SAMPLE_W-1:0] chan_in,
    input  logic [CHSEL_W-1:0]         chan_sel,
    input  logic                       use_int,
    input  logic [SAMPLE_W-1:0]        ref_int,
    input  logic [SAMPLE_W-1:0]        ref_ext,
    output logic                       chan_ok,
    output logic [RES_W-1:0]           result
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [SAMPLE_W-1:0] ch_arr [NUM_CH];
    logic [SAMPLE_W-1:0] smp;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign ch_arr[g] = chan_in[g*SAMPLE_W +: SAMPLE_W];
    end

    assign chan_ok = ({28'd0, chan_sel} < NUM_CH);
    assign smp     = chan_ok ? ch_arr[IDX_W'(chan_sel)] : '0;
    assign result  = ratio_scale(smp, use_int ? ref_int : ref_ext);
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
    import adc_conv_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int CONV_TICKS = 20,
    parameter int ADDR_W     = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_wr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [NUM_CH*SAMPLE_W-1:0] chan_in,
    input  logic [SAMPLE_W-1:0]        ref_int,
    input  logic [SAMPLE_W-1:0]        ref_ext,
    output logic                       irq
);
    ctl_t             con_q;
    ctl_t             wr_v;
    logic [31:0]      data_q;
    reg_sel_e         sel;
    logic             ctl_wr;
    logic             sr_wr;
    logic             tmr_load;
    logic             tmr_abort;
    logic             tmr_done;
    logic             cmpl;
    logic             chan_ok;
    logic [RES_W-1:0] result;

    always_comb begin
        sel = SEL_NONE;
        if (bus_addr[1:0] == 2'b00) begin
            if (bus_addr[ADDR_W-1:2] == '0) sel = SEL_CTL;
            else if (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1)) sel = SEL_RES;
        end
    end

    always_comb begin
        wr_v = ctl_t'(bus_wdata);
        wr_v.flag = bus_wdata[18] ? 1'b0 : con_q.flag;
    end

    assign ctl_wr    = bus_wr && (sel == SEL_CTL);
    assign sr_wr     = ctl_wr && wr_v.srst;
    assign tmr_load  = ctl_wr && !wr_v.srst && wr_v.enable && wr_v.start && !con_q.start;
    assign tmr_abort = sr_wr || (ctl_wr && wr_v.enable && !wr_v.start);
    assign cmpl      = tmr_done && !ctl_wr;

    adc_tick_timer #(
        .DIV_W      (DIV_W),
        .CONV_TICKS (CONV_TICKS)
    ) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .load  (tmr_load),
        .abort (tmr_abort),
        .div   (wr_v.div),
        .done  (tmr_done)
    );

    adc_chan_scaler #(
        .NUM_CH (NUM_CH)
    ) u_scl (
        .chan_in  (chan_in),
        .chan_sel (con_q.chan),
        .use_int  (con_q.ref_int),
        .ref_int  (ref_int),
        .ref_ext  (ref_ext),
        .chan_ok  (chan_ok),
        .result   (result)
    );

    always_ff @(posedge clk) begin
        if (rst || sr_wr) begin
            con_q  <= ctl_t'(CTL_RST_VAL);
            data_q <= '0;
            irq    <= 1'b0;
        end else if (ctl_wr) begin
            con_q <= wr_v;
            if (bus_wdata[18]) irq <= 1'b0;
        end else if (cmpl && chan_ok) begin
            data_q      <= {{(32-RES_W){1'b0}}, result};
            con_q.start <= 1'b0;
            if (con_q.int_en) begin
                con_q.flag <= 1'b1;
                irq        <= 1'b1;
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_CTL: bus_rdata = con_q;
            SEL_RES: bus_rdata = data_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              irq,
    input logic [31:0]       con_q,
    input logic [31:0]       data_q,
    input logic              cmpl,
    input logic              chan_ok
);
    logic rst_d;
    logic ctl_hit;
    logic sr_hit;

    assign ctl_hit = bus_wr && (bus_addr == '0);
    assign sr_hit  = ctl_hit && bus_wdata[16];

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            a_r1_reset_vals: assert (con_q == 32'h000C_0001 && data_q == 32'd0 && !irq)
                else $error("R1 reset values wrong");
        end
    end

    a_r2_data_hold: assert property (@(posedge clk) disable iff (rst)
        (!cmpl && !sr_hit) |=> $stable(data_q));

    a_r5_done_clears_start: assert property (@(posedge clk) disable iff (rst)
        (cmpl && chan_ok) |=> !con_q[13]);

    a_r5_irq_has_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> con_q[18]);

    a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
        (ctl_hit && bus_wdata[18] && !bus_wdata[16]) |=> (!irq && !con_q[18]));

    a_r9_bad_chan: assert property (@(posedge clk) disable iff (rst)
        (cmpl && !chan_ok) |=> (con_q[13] && $stable(irq)));
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .con_q     (con_q),
    .data_q    (data_q),
    .cmpl      (cmpl),
    .chan_ok   (chan_ok)
);

// File: tb/sim_adc_conv_ctrl.sv
`timescale 1ns/1ps
module sim_adc_conv_ctrl;
    localparam int NCH   = 8;
    localparam int TICKS = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic [11:0]   bus_addr;
    logic          bus_wr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic [NCH*32-1:0] chan_in;
    logic [31:0]   ref_int;
    logic [31:0]   ref_ext;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adc_conv_ctrl #(.NUM_CH(NCH), .CONV_TICKS(TICKS), .ADDR_W(12)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_in(chan_in),
        .ref_int(ref_int), .ref_ext(ref_ext), .irq(irq)
    );

    function automatic logic [31:0] exp_scale(input logic [31:0] s, input logic [31:0] r);
        longint unsigned q;
        q = (longint'(s) * 1024) / longint'(r);
        return (q > 1023) ? 32'd1023 : 32'(q);
    endfunction

    function automatic logic [31:0] mk(input int ch, input bit ie, input bit rs,
                                       input bit en, input bit st, input bit clr, input int dv);
        logic [31:0] w;
        w = '0;
        w[27:24] = 4'(ch);
        w[21] = ie; w[19] = rs; w[18] = clr; w[17] = en; w[13] = st;
        w[8:1] = 8'(dv);
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ch(input int ch, input logic [31:0] v);
        chan_in[ch*32 +: 32] = v;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, old, smp, rsel;
        int n, ch, dv;
        bit ie, rs;
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        chan_in = '0; ref_int = 32'd2000000; ref_ext = 32'd3000000;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        rd(12'h0, v); chk("R1 ctl", v, 32'h000C0001);
        rd(12'h4, v); chk("R1 data", v, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        // R2 unmapped and misaligned
        rd(12'h8, v); chk("R2 unmapped", v, 32'd0);
        rd(12'h2, v); chk("R2 misaligned", v, 32'd0);

        // R3/R4/R5 directed: ch2, div 1, internal ref, int enabled
        set_ch(2, 32'd500000);
        n = TICKS * 2 * 2;
        wr(12'h0, mk(2, 1, 1, 1, 0, 1, 1));
        wr(12'h0, mk(2, 1, 1, 1, 1, 0, 1));
        wait_cyc(n - 1);
        rd(12'h0, v); chk("R3 busy before end", {31'd0, v[13]}, 32'd1);
        wait_cyc(1);
        rd(12'h0, v); chk("R5 start cleared", {31'd0, v[13]}, 32'd0);
        chk("R5 flag set", {31'd0, v[18]}, 32'd1);
        chk("R5 irq", {31'd0, irq}, 32'd1);
        rd(12'h4, v); chk("R4 value", v, 32'd256);

        // R2 result write ignored
        wr(12'h4, 32'hFFFF_FFFF);
        rd(12'h4, v); chk("R2 result ro", v, 32'd256);

        // R6 write 0 keeps, write 1 clears
        wr(12'h0, mk(2, 1, 1, 1, 0, 0, 1));
        rd(12'h0, v); chk("R6 keep flag", {31'd0, v[18]}, 32'd1);
        chk("R6 keep irq", {31'd0, irq}, 32'd1);
        wr(12'h0, mk(2, 1, 1, 1, 0, 1, 1));
        rd(12'h0, v); chk("R6 clear flag", {31'd0, v[18]}, 32'd0);
        chk("R6 clear irq", {31'd0, irq}, 32'd0);

        // R4 saturation, external reference, R11 no interrupt
        set_ch(5, 32'hFFFF_0000);
        n = TICKS * 2;
        wr(12'h0, mk(5, 0, 0, 1, 1, 0, 0));
        wait_cyc(n);
        rd(12'h4, v); chk("R4 saturate", v, 32'd1023);
        rd(12'h0, v); chk("R11 no flag", {31'd0, v[18]}, 32'd0);
        chk("R11 no irq", {31'd0, irq}, 32'd0);

        // R7 repeated start does not restart
        set_ch(1, 32'd1000000);
        n = TICKS * 2;
        wr(12'h0, mk(1, 0, 0, 1, 1, 0, 0));
        wait_cyc(18);
        wr(12'h0, mk(1, 0, 0, 1, 1, 0, 0));
        wait_cyc(n - 21);
        rd(12'h0, v); chk("R7 no restart busy", {31'd0, v[13]}, 32'd1);
        wait_cyc(1);
        rd(12'h0, v); chk("R7 no restart done", {31'd0, v[13]}, 32'd0);
        rd(12'h4, v); chk("R7 value", v, exp_scale(32'd1000000, ref_ext));

        // R7 abort
        rd(12'h4, old);
        set_ch(1, 32'd10);
        wr(12'h0, mk(1, 0, 0, 1, 1, 0, 0));
        wait_cyc(10);
        wr(12'h0, mk(1, 0, 0, 1, 0, 0, 0));
        wait_cyc(TICKS * 2 + 10);
        rd(12'h4, v); chk("R7 abort data", v, old);

        // R9 invalid channel
        wr(12'h0, mk(9, 1, 0, 1, 1, 1, 0));
        wait_cyc(TICKS * 2 + 10);
        rd(12'h4, v); chk("R9 data kept", v, old);
        rd(12'h0, v); chk("R9 start kept", {31'd0, v[13]}, 32'd1);
        chk("R9 no irq", {31'd0, irq}, 32'd0);
        wr(12'h0, mk(1, 0, 0, 1, 0, 0, 0));

        // R10 start while disabled
        wr(12'h0, mk(1, 1, 0, 0, 1, 0, 0));
        wait_cyc(TICKS * 2 + 10);
        rd(12'h4, v); chk("R10 data kept", v, old);
        rd(12'h0, v); chk("R10 start stored", {31'd0, v[13]}, 32'd1);
        wr(12'h0, mk(1, 0, 0, 0, 0, 0, 0));

        // R8 soft reset mid-conversion with pending irq
        set_ch(0, 32'd100);
        wr(12'h0, mk(0, 1, 0, 1, 1, 0, 0));
        wait_cyc(TICKS * 2);
        chk("R8 pre irq", {31'd0, irq}, 32'd1);
        wr(12'h0, mk(0, 1, 0, 1, 0, 0, 0));
        wr(12'h0, mk(0, 1, 0, 1, 1, 0, 0));
        wait_cyc(5);
        wr(12'h0, 32'h0001_2000 | mk(3, 1, 0, 1, 1, 0, 7));
        rd(12'h0, v); chk("R8 ctl", v, 32'h000C0001);
        rd(12'h4, v); chk("R8 data", v, 32'd0);
        chk("R8 irq", {31'd0, irq}, 32'd0);
        wait_cyc(TICKS * 2 + 5);
        rd(12'h4, v); chk("R8 cancelled", v, 32'd0);

        // random conversions
        for (int it = 0; it < 40; it++) begin
            ch = int'($urandom % NCH);
            dv = int'($urandom % 8);
            ie = 1'($urandom % 2);
            rs = 1'($urandom % 2);
            ref_int = ($urandom % 100000) + 1;
            ref_ext = ($urandom % 100000) + 1;
            rsel = rs ? ref_int : ref_ext;
            smp = (it % 4 == 0) ? $urandom : ($urandom % (rsel + 1));
            set_ch(ch, smp);
            n = TICKS * 2 * (dv + 1);
            wr(12'h0, mk(ch, ie, rs, 1, 0, 1, dv));
            wr(12'h0, mk(ch, ie, rs, 1, 1, 0, dv));
            wait_cyc(n - 1);
            rd(12'h0, v); chk("R3 rand busy", {31'd0, v[13]}, 32'd1);
            wait_cyc(1);
            rd(12'h0, v); chk("R3 rand done", {31'd0, v[13]}, 32'd0);
            chk("R5 rand flag", {31'd0, v[18]}, {31'd0, ie});
            chk("R5 rand irq", {31'd0, irq}, {31'd0, ie});
            rd(12'h4, v); chk("R4 rand value", v, exp_scale(smp, rsel));
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule